// File: doc/BRIEF.md
# Single-Bank OUT Endpoint Receive Buffer

This block sits between an already-decoded USB packet stream and a local consumer. After an OUT token it takes the bytes of one data packet into a single on-chip bank. When the end-of-packet marker arrives it answers with a one-cycle ACK or NAK. A packet that lands in an empty bank is kept, the bank is marked ready, an interrupt pulse is raised and the byte count is latched. While the bank still holds unread bytes, every further data packet is refused with NAK, and the host sends it again later.

The application drains the bank through a simple read port. The read data always shows the next unread byte, and each read strobe moves on by one byte. The bank frees itself when the last byte is consumed.

Zero-length packets take one of two paths, chosen by a mode input:
- In manual mode the ready flag is set with a count of zero, and a single read strobe releases it.
- In auto mode the ready flag is never set, and a separate end-of-transfer pulse reports the event.

Packets with a bad CRC are dropped silently. Payloads longer than the bank are flagged as an overflow and refused.

Top module: `out_bank_ep`

## Requirements
- R1: An OUT token seen while `bank_rdy` is 0 opens a receive. The payload bytes (`pkt_vld`, on cycles without `pkt_eop`) are stored in order. The cycle after `pkt_eop` with `pkt_crc_ok`=1, `hs_ack` pulses high for one cycle.
- R2: On that same cycle, for a stored packet of one or more bytes, `bank_rdy` is 1, `rdy_irq` pulses for one cycle and `byte_cnt` equals the number of payload bytes.
- R3: An OUT token seen while `bank_rdy` is 1 makes the following good packet end with a one-cycle `hs_nak` and no ACK. The bank contents, `byte_cnt` and `bank_rdy` are left as they were. Busy is judged by `bank_rdy` as it stands in the token cycle.
- R4: While `bank_rdy` is 1, `rd_data` shows the next unread byte, starting from the first. Each `rd_en` advances by one byte. After `byte_cnt` strobes, `bank_rdy` is 0 from the next cycle on, and the next packet is accepted with ACK.
- R5: With `auto_zlp`=0, a zero-length packet into a free bank gives ACK, a `rdy_irq` pulse, `byte_cnt`=0 and `bank_rdy`=1. A single `rd_en` then clears `bank_rdy`.
- R6: With `auto_zlp`=1, a zero-length packet into a free bank gives ACK, a `rdy_irq` pulse and `byte_cnt`=0. It also gives a one-cycle `eot_evt` pulse, and `bank_rdy` stays 0.
- R7: A packet that ends with `pkt_crc_ok`=0 gets neither ACK nor NAK, and leaves `bank_rdy`, `byte_cnt` and the stored data unchanged.
- R8: A good packet carrying more than MAX_PKT bytes into a free bank ends with `hs_nak` and a one-cycle `ovf` pulse on the same cycle. `bank_rdy` stays 0 and `byte_cnt` is unchanged.
- R9: `rd_en` while `bank_rdy` is 0 has no effect. `bank_rdy` and `byte_cnt` are unchanged, and the next stored packet reads from its first byte.
- R10: Synchronous active-high `rst` leaves `bank_rdy`, `byte_cnt`, `hs_ack`, `hs_nak`, `rdy_irq`, `eot_evt` and `ovf` all at 0.
- R11: `pkt_vld` and `pkt_eop` that arrive outside an open receive (no preceding token) produce no handshake and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_zlp | input | 1 | 1 selects auto handling of zero-length packets |
| tok_out | input | 1 | One-cycle strobe: OUT token addressed to this endpoint |
| pkt_vld | input | 1 | Payload byte valid |
| pkt_byte | input | DW | Payload byte |
| pkt_eop | input | 1 | End of data packet (carries no byte) |
| pkt_crc_ok | input | 1 | CRC result, sampled with `pkt_eop` |
| rd_en | input | 1 | Application read strobe |
| rd_data | output | DW | Next unread byte of the bank |
| hs_ack | output | 1 | ACK pulse, one cycle after end of packet |
| hs_nak | output | 1 | NAK pulse, one cycle after end of packet |
| bank_rdy | output | 1 | Bank holds a packet for the application |
| rdy_irq | output | 1 | One-cycle interrupt when a packet is taken |
| eot_evt | output | 1 | End-of-transfer pulse for a zero-length packet in auto mode |
| byte_cnt | output | $clog2(MAX_PKT+1) | Byte count of the last accepted packet |
| ovf | output | 1 | Overflow pulse with the NAK of an oversized payload |

## Verification
Two functions can meet in one cycle: the application's final read, which frees the bank, and the host side's next transaction. The bench provokes this twice. First it places the last `rd_en` on the token cycle of a new packet. Then it places the last `rd_en` on that packet's end-of-packet cycle. In both cases the packet must be refused with NAK, because busy was judged at the token, and `bank_rdy` must still drop. A further packet must then be accepted with ACK and read back correctly.

// File: rtl/oeb_pkg.sv
package oeb_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_TAKE = 2'd1,
        RX_DROP = 2'd2
    } rx_state_e;
endpackage

// File: rtl/oeb_bank_ram.sv
module oeb_bank_ram #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells_q[rd_addr];
endmodule

// File: rtl/oeb_rx_ctrl.sv
module oeb_rx_ctrl
    import oeb_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int DW      = 8,
    localparam int CW     = $clog2(MAX_PKT + 1),
    localparam int AW     = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tok_out,
    input  logic          pkt_vld,
    input  logic [DW-1:0] pkt_byte,
    input  logic          pkt_eop,
    input  logic          pkt_crc_ok,
    input  logic          bank_busy,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          commit,
    output logic [CW-1:0] commit_cnt,
    output logic          commit_zlp,
    output logic          hs_ack,
    output logic          hs_nak,
    output logic          ovf
);
    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] wptr;
        logic          too_long;
        logic          ack;
        logic          nak;
        logic          ovf;
    } rx_regs_t;

    rx_regs_t rx_q, rx_d;
    logic     commit_c;
    logic     wr_c;

    always_comb begin
        rx_d     = rx_q;
        rx_d.ack = 1'b0;
        rx_d.nak = 1'b0;
        rx_d.ovf = 1'b0;
        commit_c = 1'b0;
        wr_c     = 1'b0;
        if (tok_out) begin
            rx_d.st       = bank_busy ? RX_DROP : RX_TAKE;
            rx_d.wptr     = '0;
            rx_d.too_long = 1'b0;
        end else begin
            unique case (rx_q.st)
                RX_TAKE: begin
                    if (pkt_eop) begin
                        rx_d.st = RX_IDLE;
                        if (pkt_crc_ok) begin
                            if (rx_q.too_long) begin
                                rx_d.nak = 1'b1;
                                rx_d.ovf = 1'b1;
                            end else begin
                                rx_d.ack = 1'b1;
                                commit_c = 1'b1;
                            end
                        end
                    end else if (pkt_vld) begin
                        if (rx_q.wptr == CW'(MAX_PKT)) begin
                            rx_d.too_long = 1'b1;
                        end else begin
                            wr_c      = 1'b1;
                            rx_d.wptr = rx_q.wptr + 1'b1;
                        end
                    end
                end
                RX_DROP: begin
                    if (pkt_eop) begin
                        rx_d.st  = RX_IDLE;
                        rx_d.nak = pkt_crc_ok;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '{st: RX_IDLE, wptr: '0, too_long: 1'b0,
                      ack: 1'b0, nak: 1'b0, ovf: 1'b0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign wr_en      = wr_c;
    assign wr_addr    = rx_q.wptr[AW-1:0];
    assign wr_data    = pkt_byte;
    assign commit     = commit_c;
    assign commit_cnt = rx_q.wptr;
    assign commit_zlp = (rx_q.wptr == '0);
    assign hs_ack     = rx_q.ack;
    assign hs_nak     = rx_q.nak;
    assign ovf        = rx_q.ovf;

    // R1: a handshake only follows an end-of-packet
    assert_hs_after_eop_R1: assert property (@(posedge clk) disable iff (rst)
        (hs_ack || hs_nak) |-> $past(pkt_eop));
    // R3: never both answers at once
    assert_ack_nak_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(hs_ack && hs_nak));
    // R3: no write lands in a bank that is holding a packet
    assert_no_write_busy_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !bank_busy);
    // R8: overflow always comes with a NAK
    assert_no_overflow_ack_R8: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (hs_nak && !hs_ack));
endmodule

// File: rtl/oeb_bank_state.sv
module oeb_bank_state #(
    parameter int MAX_PKT = 64,
    localparam int CW     = $clog2(MAX_PKT + 1),
    localparam int AW     = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_zlp,
    input  logic          commit,
    input  logic [CW-1:0] commit_cnt,
    input  logic          commit_zlp,
    input  logic          rd_en,
    output logic          bank_rdy,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] byte_cnt,
    output logic          rdy_irq,
    output logic          eot_evt
);
    typedef struct packed {
        logic          rdy;
        logic [CW-1:0] left;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          irq;
        logic          eot;
    } bk_regs_t;

    bk_regs_t bk_q, bk_d;

    always_comb begin
        bk_d     = bk_q;
        bk_d.irq = 1'b0;
        bk_d.eot = 1'b0;
        if (bk_q.rdy && rd_en) begin
            if (bk_q.left <= CW'(1)) begin
                bk_d.rdy  = 1'b0;
                bk_d.left = '0;
                bk_d.rptr = '0;
            end else begin
                bk_d.left = bk_q.left - 1'b1;
                bk_d.rptr = bk_q.rptr + 1'b1;
            end
        end
        if (commit) begin
            bk_d.rdy  = !(commit_zlp && auto_zlp);
            bk_d.cnt  = commit_cnt;
            bk_d.left = commit_cnt;
            bk_d.rptr = '0;
            bk_d.irq  = 1'b1;
            bk_d.eot  = commit_zlp && auto_zlp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bk_q <= '{rdy: 1'b0, left: '0, rptr: '0, cnt: '0,
                      irq: 1'b0, eot: 1'b0};
        end else begin
            bk_q <= bk_d;
        end
    end

    assign bank_rdy = bk_q.rdy;
    assign rd_addr  = bk_q.rptr;
    assign byte_cnt = bk_q.cnt;
    assign rdy_irq  = bk_q.irq;
    assign eot_evt  = bk_q.eot;

    // R3: a packet is never committed over unread data
    assert_commit_free_R3: assert property (@(posedge clk) disable iff (rst)
        commit |-> !bank_rdy);
    // R4: the bank only empties in response to a read strobe
    assert_rdy_fall_read_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(bank_rdy) |-> $past(rd_en));
    // R2: the interrupt pulse follows a commit
    assert_irq_after_commit_R2: assert property (@(posedge clk) disable iff (rst)
        rdy_irq |-> $past(commit));
    // R6: end-of-transfer leaves the bank free with a zero count
    assert_eot_free_R6: assert property (@(posedge clk) disable iff (rst)
        eot_evt |-> (!bank_rdy && byte_cnt == '0 && rdy_irq));
endmodule

// File: rtl/out_bank_ep.sv
module out_bank_ep #(
    parameter int MAX_PKT = 64,
    parameter int DW      = 8,
    localparam int CW     = $clog2(MAX_PKT + 1),
    localparam int AW     = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_zlp,
    input  logic          tok_out,
    input  logic          pkt_vld,
    input  logic [DW-1:0] pkt_byte,
    input  logic          pkt_eop,
    input  logic          pkt_crc_ok,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          hs_ack,
    output logic          hs_nak,
    output logic          bank_rdy,
    output logic          rdy_irq,
    output logic          eot_evt,
    output logic [CW-1:0] byte_cnt,
    output logic          ovf
);
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] rd_addr;
    logic          commit;
    logic [CW-1:0] commit_cnt;
    logic          commit_zlp;

    oeb_rx_ctrl #(.MAX_PKT(MAX_PKT), .DW(DW)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .tok_out    (tok_out),
        .pkt_vld    (pkt_vld),
        .pkt_byte   (pkt_byte),
        .pkt_eop    (pkt_eop),
        .pkt_crc_ok (pkt_crc_ok),
        .bank_busy  (bank_rdy),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit     (commit),
        .commit_cnt (commit_cnt),
        .commit_zlp (commit_zlp),
        .hs_ack     (hs_ack),
        .hs_nak     (hs_nak),
        .ovf        (ovf)
    );

    oeb_bank_state #(.MAX_PKT(MAX_PKT)) u_state (
        .clk        (clk),
        .rst        (rst),
        .auto_zlp   (auto_zlp),
        .commit     (commit),
        .commit_cnt (commit_cnt),
        .commit_zlp (commit_zlp),
        .rd_en      (rd_en),
        .bank_rdy   (bank_rdy),
        .rd_addr    (rd_addr),
        .byte_cnt   (byte_cnt),
        .rdy_irq    (rdy_irq),
        .eot_evt    (eot_evt)
    );

    oeb_bank_ram #(.DEPTH(MAX_PKT), .DW(DW)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/out_bank_ep_bench.sv
module out_bank_ep_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXP = 8;
    localparam int CW   = $clog2(MAXP + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          auto_zlp = 1'b0;
    logic          tok_out = 1'b0;
    logic          pkt_vld = 1'b0;
    logic [7:0]    pkt_byte = '0;
    logic          pkt_eop = 1'b0;
    logic          pkt_crc_ok = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic          hs_ack, hs_nak, bank_rdy, rdy_irq, eot_evt, ovf;
    logic [CW-1:0] byte_cnt;

    int n_chk = 0;
    int n_err = 0;
    int exp_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    out_bank_ep #(.MAX_PKT(MAXP), .DW(8)) u_out_bank_ep (
        .clk(clk), .rst(rst), .auto_zlp(auto_zlp), .tok_out(tok_out),
        .pkt_vld(pkt_vld), .pkt_byte(pkt_byte), .pkt_eop(pkt_eop),
        .pkt_crc_ok(pkt_crc_ok), .rd_en(rd_en), .rd_data(rd_data),
        .hs_ack(hs_ack), .hs_nak(hs_nak), .bank_rdy(bank_rdy),
        .rdy_irq(rdy_irq), .eot_evt(eot_evt), .byte_cnt(byte_cnt), .ovf(ovf)
    );

    function automatic logic [7:0] pat(input int base, input int i);
        return 8'((base * 7 + i * 29 + 3) & 255);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // token, payload, end of packet; returns at the negedge where the handshake shows
    task automatic send_pkt(input int len, input bit crc, input int base);
        @(negedge clk);
        tok_out = 1'b1;
        @(negedge clk);
        tok_out = 1'b0;
        for (int i = 0; i < len; i++) begin
            pkt_vld  = 1'b1;
            pkt_byte = pat(base, i);
            @(negedge clk);
        end
        pkt_vld    = 1'b0;
        pkt_eop    = 1'b1;
        pkt_crc_ok = crc;
        @(negedge clk);
        pkt_eop    = 1'b0;
        pkt_crc_ok = 1'b0;
    endtask

    task automatic read_back(input int len, input int base, input string tag);
        for (int i = 0; i < len; i++) begin
            chk({tag, " rd_data"}, int'(rd_data), int'(pat(base, i)));
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk({tag, " bank_rdy after drain"}, int'(bank_rdy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 bank_rdy", int'(bank_rdy), 0);
        chk("R10 byte_cnt", int'(byte_cnt), 0);
        chk("R10 handshakes", int'({hs_ack, hs_nak, rdy_irq, eot_evt, ovf}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R11 bytes and eop without a token
        pkt_vld = 1'b1; pkt_byte = 8'h5A; @(negedge clk);
        pkt_vld = 1'b0; pkt_eop = 1'b1; pkt_crc_ok = 1'b1; @(negedge clk);
        pkt_eop = 1'b0; pkt_crc_ok = 1'b0;
        chk("R11 no handshake", int'({hs_ack, hs_nak, rdy_irq}), 0);
        chk("R11 bank_rdy", int'(bank_rdy), 0);

        // R1 R2 R4 R5 R6 R8 sweep over all lengths and both zero-length modes
        for (int m = 0; m < 2; m++) begin
            auto_zlp = m[0];
            for (int len = 0; len <= MAXP + 1; len++) begin
                int base = len * 5 + m * 50;
                send_pkt(len, 1'b1, base);
                if (len > MAXP) begin
                    chk("R8 nak", int'(hs_nak), 1);
                    chk("R8 ovf", int'(ovf), 1);
                    chk("R8 ack", int'(hs_ack), 0);
                    chk("R8 bank_rdy", int'(bank_rdy), 0);
                    chk("R8 byte_cnt", int'(byte_cnt), exp_cnt);
                end else begin
                    exp_cnt = len;
                    chk("R1 ack", int'(hs_ack), 1);
                    chk("R1 nak", int'(hs_nak), 0);
                    chk("R2 irq", int'(rdy_irq), 1);
                    chk("R2 byte_cnt", int'(byte_cnt), len);
                    if (len == 0 && m == 1) begin
                        chk("R6 bank_rdy", int'(bank_rdy), 0);
                        chk("R6 eot", int'(eot_evt), 1);
                    end else if (len == 0) begin
                        chk("R5 bank_rdy", int'(bank_rdy), 1);
                        chk("R5 eot", int'(eot_evt), 0);
                        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
                        chk("R5 release", int'(bank_rdy), 0);
                    end else begin
                        chk("R2 bank_rdy", int'(bank_rdy), 1);
                        chk("R4 eot quiet", int'(eot_evt), 0);
                        read_back(len, base, "R4");
                    end
                end
            end
        end
        auto_zlp = 1'b0;

        // R9 read strobes on an empty bank
        for (int k = 0; k < 3; k++) begin
            rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        end
        chk("R9 bank_rdy", int'(bank_rdy), 0);
        chk("R9 byte_cnt", int'(byte_cnt), exp_cnt);
        send_pkt(4, 1'b1, 91);
        exp_cnt = 4;
        chk("R9 ack", int'(hs_ack), 1);

        // R3 busy bank refuses, data kept; R7 bad CRC while busy
        send_pkt(6, 1'b1, 17);
        chk("R3 nak", int'(hs_nak), 1);
        chk("R3 ack", int'(hs_ack), 0);
        chk("R3 bank_rdy", int'(bank_rdy), 1);
        chk("R3 byte_cnt", int'(byte_cnt), 4);
        send_pkt(2, 1'b0, 23);
        chk("R7 busy no hs", int'({hs_ack, hs_nak}), 0);
        chk("R7 busy byte_cnt", int'(byte_cnt), 4);
        read_back(4, 91, "R3 kept");

        // R7 bad CRC on a free bank
        send_pkt(3, 1'b0, 44);
        chk("R7 free no hs", int'({hs_ack, hs_nak, rdy_irq}), 0);
        chk("R7 free bank_rdy", int'(bank_rdy), 0);
        chk("R7 free byte_cnt", int'(byte_cnt), 4);

        // R3 last read on the token cycle: busy at token, so NAK
        send_pkt(2, 1'b1, 60);
        chk("R3 coin1 ack A", int'(hs_ack), 1);
        chk("R4 coin1 byte0", int'(rd_data), int'(pat(60, 0)));
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk("R4 coin1 byte1", int'(rd_data), int'(pat(60, 1)));
        tok_out = 1'b1; rd_en = 1'b1; @(negedge clk);
        tok_out = 1'b0; rd_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            pkt_vld = 1'b1; pkt_byte = pat(70, i); @(negedge clk);
        end
        pkt_vld = 1'b0; pkt_eop = 1'b1; pkt_crc_ok = 1'b1; @(negedge clk);
        pkt_eop = 1'b0; pkt_crc_ok = 1'b0;
        chk("R3 coin1 nak", int'(hs_nak), 1);
        chk("R3 coin1 bank_rdy", int'(bank_rdy), 0);
        chk("R3 coin1 byte_cnt", int'(byte_cnt), 2);

        // R3 last read on the end-of-packet cycle
        send_pkt(2, 1'b1, 80);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        tok_out = 1'b1; @(negedge clk); tok_out = 1'b0;
        pkt_vld = 1'b1; pkt_byte = 8'hEE; @(negedge clk);
        pkt_vld = 1'b0; pkt_eop = 1'b1; pkt_crc_ok = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        pkt_eop = 1'b0; pkt_crc_ok = 1'b0; rd_en = 1'b0;
        chk("R3 coin2 nak", int'(hs_nak), 1);
        chk("R3 coin2 ack", int'(hs_ack), 0);
        chk("R4 coin2 bank_rdy", int'(bank_rdy), 0);
        send_pkt(5, 1'b1, 99);
        chk("R4 coin2 retry ack", int'(hs_ack), 1);
        chk("R2 coin2 byte_cnt", int'(byte_cnt), 5);
        read_back(5, 99, "R4 retry");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule